// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a simple 32-bit register bus and a byte-level serial engine. It decodes word offsets, holds the control, status, FIFO-control, baud and one-millisecond registers, and keeps a one-character buffer for each direction. It sends no bits on a wire: a write to the transmit-data word produces a one-cycle byte strobe toward the serialiser. A byte or break event from the receiver lands in a single-entry receive buffer, and the buffer is drained by a bus read. A single level interrupt combines the receive-ready and transmit-ready events under their enables.

Reads are combinational from the registered state and complete in the cycle the select is high. Every side effect of a read (draining the receive buffer) and every write takes effect at the clock edge that closes that bus cycle. The reset state leaves the port enabled with transmit on, so output is possible before any software setup.

Top module: `uart_regfile`

## Requirements
- R1: After reset: status-1 reads 0x6040 (transmit-ready bit 13, RTS-status bit 14, receive-start bit 6), status-2 reads 0x4028, test register (index 0x2D) reads 0x0060 (RX-empty bit 5, TX-empty bit 6), control-1 reads 0x0001, control-2 reads 0x0004, control-3 reads 0x0700, baud count reads 4, modulator, FIFO control and one-ms read 0, and the receive word (index 0x00) reads 0x4000 (error flag bit 14).
- R2: The word index is the byte address shifted right by 2. Control 1..4 are at indices 0x20..0x23, FIFO control at 0x24, status 1/2 at 0x25/0x26, baud increment 0x29, modulator 0x2A, baud count 0x2B, one-ms 0x2C, test 0x2D. A write to index 0x29 updates the value read at 0x2B; reads of 0x23 and 0x29 return 0; any unlisted index reads 0 and ignores writes.
- R3: Writes to control 1, 2, 3, FIFO control, modulator, baud increment and one-ms keep only bits 15:0.
- R4: Writing control-2 with bit 0 equal to 0 restores the R1 values of both status registers, test register, receive word, control-1 (to 0), control-3, modulator and baud count; FIFO control and one-ms are kept, and control-2 then reads the written low 16 bits with bit 0 set.
- R5: A write to index 0x10 while control-2 bit 2 is set raises tx_strobe for the next cycle with tx_byte equal to write bits 7:0, and status-1 bit 13 reads 0 in that cycle and 1 again in the one after. With bit 2 clear the write has no effect.
- R6: rx_ready equals the inverse of status-1 bit 9. A byte with rx_valid and rx_ready high sets status-1 bit 9 and status-2 bit 0, clears test bit 5 and is stored in the receive word; with rx_ready low the byte is dropped and the buffer is unchanged.
- R7: An accepted rx_valid with rx_break high stores 0x0800 in the receive word in place of the byte.
- R8: A read of index 0x00 while test bit 5 is 0 returns the stored word with bit 15 set and clears status-1 bit 9 and status-2 bit 0 and sets test bit 5; while test bit 5 is 1 it returns the stored word without bit 15 and changes nothing.
- R9: irq is high when status-1 bit 9 and control-1 bit 9 are both set, or when control-1 bit 6 is set and either test bit 6 is set or status-1 bit 13 and control-1 bit 13 are both set; otherwise low.
- R10: A write to status-1 clears only the bits set in both the written value and mask 0x9DB0; a write to status-2 only those in mask 0xBDD6. No other bit changes.
- R11: Writes to the test register (0x2D) and control-4 (0x23) change no readable state.
- R12: Within one cycle the bus operation is applied first and a receive accept second, the accept decided by the rx_ready value of that cycle; a soft reset and an accepted byte in the same cycle leave the byte in the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset to the boot state |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| tx_byte | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle strobe qualifying tx_byte |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Incoming event is a break rather than a byte |
| rx_valid | input | 1 | Receive event offered |
| rx_ready | output | 1 | Receive buffer can accept |
| irq | output | 1 | Level interrupt |

## Verification
The receive path meets the bus in the same cycle in two ways: a draining read of index 0x00 while a new byte is offered, and a soft reset through control-2 while a byte is accepted. The bench provokes both directly and again at random, holding rx_valid high across the drain so the dropped byte and the accept one cycle later are both visible. The reference model applies the bus effect first and the accept second from the pre-edge buffer state, and every cycle's read data, rx_ready, irq and strobe are compared against it.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

    localparam int REG_W = 16;

    // word indices
    localparam int IX_RXD  = 'h00;
    localparam int IX_TXD  = 'h10;
    localparam int IX_CTL1 = 'h20;
    localparam int IX_CTL2 = 'h21;
    localparam int IX_CTL3 = 'h22;
    localparam int IX_CTL4 = 'h23;
    localparam int IX_FIFO = 'h24;
    localparam int IX_ST1  = 'h25;
    localparam int IX_ST2  = 'h26;
    localparam int IX_BINC = 'h29;
    localparam int IX_BMOD = 'h2A;
    localparam int IX_BCNT = 'h2B;
    localparam int IX_MSEC = 'h2C;
    localparam int IX_TEST = 'h2D;

    // bit positions
    localparam int S1_RXDS = 6;
    localparam int S1_RRDY = 9;
    localparam int S1_TRDY = 13;
    localparam int S1_RTSS = 14;
    localparam int S2_RDR   = 0;
    localparam int S2_TXDC  = 3;
    localparam int S2_DCDIN = 5;
    localparam int S2_TXFE  = 14;
    localparam int T_RXE = 5;
    localparam int T_TXE = 6;
    localparam int C1_EN     = 0;
    localparam int C1_TXEIE  = 6;
    localparam int C1_RRDYIE = 9;
    localparam int C1_TRDYIE = 13;
    localparam int C2_SRST = 0;
    localparam int C2_TXEN = 2;
    localparam int RB_BRK = 11;
    localparam int RB_ERR = 14;
    localparam int RB_RDY = 15;

    localparam logic [REG_W-1:0] ST1_W1C = 16'h9DB0;
    localparam logic [REG_W-1:0] ST2_W1C = 16'hBDD6;

    typedef struct packed {
        logic [REG_W-1:0] st1;
        logic [REG_W-1:0] st2;
        logic [REG_W-1:0] tst;
        logic [REG_W-1:0] ctl1;
        logic [REG_W-1:0] ctl2;
        logic [REG_W-1:0] ctl3;
        logic [REG_W-1:0] fifo;
        logic [REG_W-1:0] bmod;
        logic [REG_W-1:0] bcnt;
        logic [REG_W-1:0] msec;
        logic [REG_W-1:0] rbuf;
        logic             txv;
        logic [7:0]       txd;
    } uart_state_t;

    // status reset applied by a soft reset; FIFO and one-ms untouched
    function automatic uart_state_t soft_clear(uart_state_t s);
        uart_state_t r;
        r = s;
        r.st1 = '0;
        r.st1[S1_TRDY] = 1'b1;
        r.st1[S1_RXDS] = 1'b1;
        r.st1[S1_RTSS] = 1'b1;
        r.st2 = '0;
        r.st2[S2_TXFE]  = 1'b1;
        r.st2[S2_TXDC]  = 1'b1;
        r.st2[S2_DCDIN] = 1'b1;
        r.tst = '0;
        r.tst[T_RXE] = 1'b1;
        r.tst[T_TXE] = 1'b1;
        r.ctl1 = '0;
        r.ctl3 = 16'h0700;
        r.bmod = '0;
        r.bcnt = 16'd4;
        r.rbuf = '0;
        r.rbuf[RB_ERR] = 1'b1;
        return r;
    endfunction

    function automatic uart_state_t boot_state();
        uart_state_t r;
        r = soft_clear('0);
        r.ctl1[C1_EN]   = 1'b1;
        r.ctl2[C2_TXEN] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
    input  logic rrdy,
    input  logic trdy,
    input  logic tx_empty,
    input  logic rrdy_ie,
    input  logic trdy_ie,
    input  logic txe_ie,
    output logic irq
);
    logic rx_term;
    logic tx_term;

    always_comb begin
        rx_term = rrdy & rrdy_ie;
        // transmit-ready only counts when the empty enable is on
        tx_term = txe_ie & ((trdy & trdy_ie) | tx_empty);
        irq     = rx_term | tx_term;
    end
endmodule

// File: rtl/uart_rdmux.sv
module uart_rdmux
    import uart_regfile_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 32
) (
    input  uart_state_t        st,
    input  logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  rdata
);
    logic [REG_W-1:0] word;

    always_comb begin
        word = '0;
        case (idx)
            IDX_W'(IX_RXD): begin
                word = st.rbuf;
                if (!st.tst[T_RXE]) word[RB_RDY] = 1'b1;
            end
            IDX_W'(IX_CTL1): word = st.ctl1;
            IDX_W'(IX_CTL2): word = st.ctl2;
            IDX_W'(IX_CTL3): word = st.ctl3;
            IDX_W'(IX_FIFO): word = st.fifo;
            IDX_W'(IX_ST1):  word = st.st1;
            IDX_W'(IX_ST2):  word = st.st2;
            IDX_W'(IX_BMOD): word = st.bmod;
            IDX_W'(IX_BCNT): word = st.bcnt;
            IDX_W'(IX_MSEC): word = st.msec;
            IDX_W'(IX_TEST): word = st.tst;
            default:         word = '0;
        endcase
        rdata = DATA_W'(word);
    end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regfile_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_strobe,
    input  logic [7:0]        rx_byte,
    input  logic              rx_break,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    uart_state_t       s_d, s_q;
    logic [IDX_W-1:0]  idx;
    logic              wr_en, rd_en;
    logic [REG_W-1:0]  wlo;
    logic              tx_fire, srst_wr, rxd_drain, rx_take;

    always_comb begin
        idx       = bus_addr[ADDR_W-1:2];
        wr_en     = bus_sel & bus_we;
        rd_en     = bus_sel & ~bus_we;
        wlo       = bus_wdata[REG_W-1:0];
        tx_fire   = wr_en && (idx == IDX_W'(IX_TXD)) && s_q.ctl2[C2_TXEN];
        srst_wr   = wr_en && (idx == IDX_W'(IX_CTL2)) && !wlo[C2_SRST];
        rxd_drain = rd_en && (idx == IDX_W'(IX_RXD)) && !s_q.tst[T_RXE];
        rx_take   = rx_valid && !s_q.st1[S1_RRDY];
    end

    always_comb begin
        s_d = s_q;
        s_d.txv = 1'b0;
        if (s_q.txv) s_d.st1[S1_TRDY] = 1'b1;

        if (wr_en) begin
            case (idx)
                IDX_W'(IX_TXD): if (tx_fire) begin
                    s_d.txv = 1'b1;
                    s_d.txd = bus_wdata[7:0];
                    s_d.st1[S1_TRDY] = 1'b0;
                end
                IDX_W'(IX_CTL1): s_d.ctl1 = wlo;
                IDX_W'(IX_CTL2): begin
                    if (srst_wr) s_d = soft_clear(s_d);
                    s_d.ctl2 = wlo;
                    s_d.ctl2[C2_SRST] = 1'b1;
                end
                IDX_W'(IX_CTL3): s_d.ctl3 = wlo;
                IDX_W'(IX_FIFO): s_d.fifo = wlo;
                IDX_W'(IX_ST1):  s_d.st1  = s_d.st1 & ~(wlo & ST1_W1C);
                IDX_W'(IX_ST2):  s_d.st2  = s_d.st2 & ~(wlo & ST2_W1C);
                IDX_W'(IX_BINC): s_d.bcnt = wlo;
                IDX_W'(IX_BMOD): s_d.bmod = wlo;
                IDX_W'(IX_MSEC): s_d.msec = wlo;
                default: ;
            endcase
        end

        if (rxd_drain) begin
            s_d.st1[S1_RRDY] = 1'b0;
            s_d.st2[S2_RDR]  = 1'b0;
            s_d.tst[T_RXE]   = 1'b1;
        end

        // receive accept is applied after the bus effect
        if (rx_take) begin
            s_d.st1[S1_RRDY] = 1'b1;
            s_d.st2[S2_RDR]  = 1'b1;
            s_d.tst[T_RXE]   = 1'b0;
            if (rx_break) begin
                s_d.rbuf = '0;
                s_d.rbuf[RB_BRK] = 1'b1;
            end else begin
                s_d.rbuf = REG_W'(rx_byte);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= boot_state();
        else        s_q <= s_d;
    end

    uart_rdmux #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_rdmux (
        .st    (s_q),
        .idx   (idx),
        .rdata (bus_rdata)
    );

    uart_irq_gen i_irq (
        .rrdy     (s_q.st1[S1_RRDY]),
        .trdy     (s_q.st1[S1_TRDY]),
        .tx_empty (s_q.tst[T_TXE]),
        .rrdy_ie  (s_q.ctl1[C1_RRDYIE]),
        .trdy_ie  (s_q.ctl1[C1_TRDYIE]),
        .txe_ie   (s_q.ctl1[C1_TXEIE]),
        .irq      (irq)
    );

    always_comb begin
        tx_byte   = s_q.txd;
        tx_strobe = s_q.txv;
        rx_ready  = !s_q.st1[S1_RRDY];
    end

    // R5
    tx_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(tx_fire));
    // R5
    trdy_low_during_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> !s_q.st1[S1_TRDY]);
    // R6
    rx_accept_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (s_q.st1[S1_RRDY] && !s_q.tst[T_RXE] && !rx_ready));
    // R6
    rx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st1[S1_RRDY] && !rxd_drain && !srst_wr) |=> $stable(s_q.rbuf));
    // R4
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (s_q.ctl2[C2_SRST] && s_q.ctl1 == '0 && s_q.bcnt == 16'd4));
    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctl1[C1_TXEIE] && !s_q.st1[S1_RRDY]) |-> !irq);
    // R10
    st1_w1c_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(IX_ST1) && !rx_take && !tx_strobe)
        |=> ((s_q.st1 & ~$past(s_q.st1)) == '0));
endmodule

// File: tb/test_uart_regfile.sv
`timescale 1ns/1ps
module test_uart_regfile;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [7:0]        tx_byte;
    logic              tx_strobe;
    logic [7:0]        rx_byte = '0;
    logic              rx_break = 1'b0, rx_valid = 1'b0;
    logic              rx_ready, irq;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_st1, m_st2, m_ts, m_c1, m_c2, m_c3, m_fcr, m_bmod, m_bcnt, m_ms, m_rbuf, m_txd;
    bit m_txv;

    always #2 clk = ~clk;

    uart_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_uart_regfile (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_strobe(tx_strobe), .rx_byte(rx_byte),
        .rx_break(rx_break), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq));

    task automatic model_soft();
        m_st1 = 'h6040; m_st2 = 'h4028; m_ts = 'h60; m_c1 = 0; m_c3 = 'h700;
        m_bmod = 0; m_bcnt = 4; m_rbuf = 'h4000;
    endtask

    task automatic model_boot();
        model_soft();
        m_c1 = 1; m_c2 = 4; m_fcr = 0; m_ms = 0; m_txv = 0; m_txd = 0;
    endtask

    function automatic int m_read(int idx);
        case (idx)
            'h00: return m_rbuf | (((m_ts & 'h20) != 0) ? 0 : 'h8000);
            'h20: return m_c1;   'h21: return m_c2;   'h22: return m_c3;
            'h24: return m_fcr;  'h25: return m_st1;  'h26: return m_st2;
            'h2A: return m_bmod; 'h2B: return m_bcnt; 'h2C: return m_ms;
            'h2D: return m_ts;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_irq();
        int f;
        f = m_st1 & m_c1 & 'h2200;
        if ((m_c1 & 'h40) != 0) f = f | (m_ts & 'h40);
        else                    f = f & ~'h2000;
        return f != 0;
    endfunction

    task automatic model_edge(bit sel, bit we, int idx, int wd, bit rv, bit rb, int rd);
        bit was_full, was_empty, was_tx;
        int w;
        was_full = (m_st1 & 'h200) != 0;
        was_empty = (m_ts & 'h20) != 0;
        was_tx = m_txv;
        w = wd & 'hFFFF;
        m_txv = 0;
        if (was_tx) m_st1 = m_st1 | 'h2000;
        if (sel && we) begin
            case (idx)
                'h10: if ((m_c2 & 4) != 0) begin
                    m_txv = 1; m_txd = wd & 'hFF; m_st1 = m_st1 & ~'h2000;
                end
                'h20: m_c1 = w;
                'h21: begin
                    if ((w & 1) == 0) model_soft();
                    m_c2 = w | 1;
                end
                'h22: m_c3 = w;
                'h24: m_fcr = w;
                'h25: m_st1 = m_st1 & ~(w & 'h9DB0);
                'h26: m_st2 = m_st2 & ~(w & 'hBDD6);
                'h29: m_bcnt = w;
                'h2A: m_bmod = w;
                'h2C: m_ms = w;
                default: ;
            endcase
        end
        if (sel && !we && idx == 0 && !was_empty) begin
            m_st1 = m_st1 & ~'h200; m_st2 = m_st2 & ~1; m_ts = m_ts | 'h20;
        end
        if (rv && !was_full) begin
            m_st1 = m_st1 | 'h200; m_st2 = m_st2 | 1; m_ts = m_ts & ~'h20;
            m_rbuf = rb ? 'h800 : (rd & 'hFF);
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive, compare every output against the model, clock
    task automatic step(bit sel, bit we, int idx, int wd, bit rv, bit rb, int rd, string tag);
        bus_sel = sel; bus_we = we; bus_addr = ADDR_W'(idx * 4);
        bus_wdata = DATA_W'(wd); rx_valid = rv; rx_break = rb; rx_byte = rd[7:0];
        #1;
        check(tag, "irq", int'(irq), int'(m_irq()));
        check(tag, "rx_ready", int'(rx_ready), int'((m_st1 & 'h200) == 0));
        check(tag, "tx_strobe", int'(tx_strobe), int'(m_txv));
        if (m_txv) check(tag, "tx_byte", int'(tx_byte), m_txd);
        if (sel && !we) check(tag, $sformatf("rdata[%0h]", idx), int'(bus_rdata), m_read(idx));
        @(posedge clk);
        model_edge(sel, we, idx, wd, rv, rb, rd);
        @(negedge clk);
    endtask

    task automatic rd(int idx, string tag); step(1, 0, idx, 0, 0, 0, 0, tag); endtask
    task automatic wr(int idx, int v, string tag); step(1, 1, idx, v, 0, 0, 0, tag); endtask
    task automatic idle(string tag); step(0, 0, 0, 0, 0, 0, 0, tag); endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int ixs[16] = '{'h00, 'h10, 'h20, 'h21, 'h22, 'h23, 'h24, 'h25,
                        'h26, 'h29, 'h2A, 'h2B, 'h2C, 'h2D, 'h05, 'h3F};
        model_boot();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values of every readable word
        foreach (ixs[k]) rd(ixs[k], "R1");

        // R3 upper bits dropped; R2 decode and holes
        wr('h20, 'hABCD1234, "R3"); rd('h20, "R3");
        wr('h20, 1, "R3");
        wr('h24, 'h5A5A7777, "R3"); rd('h24, "R3");
        wr('h2C, 'h00012345, "R3"); rd('h2C, "R3");
        wr('h29, 'h0FFF00C8, "R2"); rd('h2B, "R2"); rd('h29, "R2");
        wr('h2A, 'h3333, "R2");     rd('h2A, "R2");
        wr('h05, 'hFFFF, "R2");     rd('h05, "R2"); rd('h3F, "R2");

        // R11 ignored writes
        wr('h2D, 0, "R11"); rd('h2D, "R11");
        wr('h23, 'hFFFF, "R11"); rd('h23, "R11");

        // R5 transmit with enable, then disabled
        wr('h10, 'h1A5, "R5"); rd('h25, "R5"); rd('h25, "R5");
        wr('h10, 'h3C, "R5"); wr('h10, 'h7E, "R5"); idle("R5"); idle("R5");
        wr('h21, 'h0001, "R5"); wr('h10, 'h55, "R5"); idle("R5"); rd('h25, "R5");
        wr('h21, 'h0005, "R5");

        // R9 interrupt gating
        wr('h20, 'h2000, "R9"); idle("R9");
        wr('h20, 'h2040, "R9"); idle("R9");
        wr('h20, 'h0200, "R9"); idle("R9");

        // R6 accept, R8 drain, drop when full
        step(0, 0, 0, 0, 1, 0, 'h3C, "R6"); idle("R9");
        step(0, 0, 0, 0, 1, 0, 'h99, "R6"); rd('h00, "R8");
        rd('h00, "R8"); rd('h25, "R8"); rd('h26, "R8"); rd('h2D, "R8");

        // R7 break
        step(0, 0, 0, 0, 1, 1, 'hFF, "R7"); rd('h00, "R7");

        // R10 write-1-to-clear masks leave live flags
        step(0, 0, 0, 0, 1, 0, 'h11, "R10");
        wr('h25, 'hFFFF, "R10"); rd('h25, "R10");
        wr('h26, 'hFFFF, "R10"); rd('h26, "R10");

        // R12 drain and offer in the same cycle, held offer
        step(1, 0, 'h00, 0, 1, 0, 'h42, "R12");
        step(0, 0, 0, 0, 1, 0, 'h42, "R12"); rd('h00, "R12");

        // R4 soft reset keeps FIFO/one-ms; R12 with byte in the same cycle
        wr('h2A, 'h1234, "R4"); wr('h22, 'h0F0F, "R4");
        wr('h21, 'h00060006, "R4");
        rd('h21, "R4"); rd('h2A, "R4"); rd('h22, "R4"); rd('h24, "R4");
        rd('h2C, "R4"); rd('h20, "R4"); rd('h25, "R4");
        step(1, 1, 'h21, 'h4, 1, 0, 'h6B, "R12"); rd('h00, "R12"); rd('h21, "R12");

        // mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            int ix;
            ix = ixs[$urandom_range(0, 15)];
            step($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, ix,
                 int'($urandom()), $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0,
                 int'($urandom_range(0, 255)), "R12");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule